// File: doc/BRIEF.md
# Daisy-Chainable Test Access Port with Persistent Debug Word

This block is a serial test access port slave. A host drives four pins (test clock, mode select, serial data in, serial data out) and walks a sixteen-state controller through instruction and data scans. A 4-bit instruction picks one of three data paths: a fixed 32-bit identity word, a single-bit pass-through stage, or a 32-bit debug word. Every instruction code that is not assigned falls back to the pass-through stage.

The debug word persists between scans. Each data scan under the debug instruction returns the word left by the scan before it. When the scan reaches its update step, the new word is also handed to the system side: one single-cycle strobe in the system clock domain, with the word beside it, so a downstream FIFO can take one entry per scan.

Several copies can be chained, each one's serial output feeding the next one's input. Each copy shifts exactly the length of its selected path, so the fields of all devices line up inside one combined scan.

Top module: `jtag_dbg_tap`

## Requirements
- R1: During Capture-IR the instruction shift stage loads 4'b0101. Bit 0 leaves on the serial output first, so the host reads 1,0,1,0.
- R2: Instruction value 4'b0010 (bit 0 shifted in first) selects the identity path. It is 32 bits long, captures 32'h149B51C3 and shifts out LSB first.
- R3: Instruction value 4'b1111 selects the pass-through path. It is one bit long and captures 0.
- R4: Every instruction value other than 4'b0010, 4'b1111 and 4'b1000 behaves exactly like 4'b1111.
- R5: Instruction value 4'b1000 selects the 32-bit debug path. The word shifted in is kept after Update-DR and is returned on the next data scan under that instruction. A scan under another instruction leaves the word unchanged.
- R6: Each Update-DR under 4'b1000 produces exactly one `push_valid` pulse, one system clock wide, with `push_word` equal to the word shifted in. No pulse occurs under any other instruction.
- R7: Five rising test-clock edges with mode select high reach Test-Logic-Reset from any state. One more edge with mode select low moves to Run-Test/Idle. Passing through Test-Logic-Reset loads 4'b0010 and clears the debug word to zero.
- R8: `tap_rst_n` low at a rising test-clock edge forces Test-Logic-Reset, loads 4'b0010 and clears the debug word. The same pin also clears the push toggle, so it must be asserted together with `rst`.
- R9: Serial input is sampled on the rising test-clock edge. `tdo` changes only on the falling edge, and it is low whenever the controller is not in Shift-IR or Shift-DR.
- R10: In a chain, each device shifts exactly its instruction length in IR scans and its selected path length in DR scans. Per-device fields therefore sit at fixed offsets in a combined scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst_n | input | 1 | Active-low port reset, sampled on rising tck |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, changes on falling tck |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| push_valid | output | 1 | One-cycle strobe per debug update |
| push_word | output | 32 | Debug word that goes with the strobe |

## Verification
A corrupted controller state shows up on the first IR scan after it. The 0101 pattern comes out shifted or is missing, and `tdo` is high outside a shift state. A wrong path length moves every downstream field in the same combined scan, so the identity words read misaligned within that one scan. A lost or doubled update is visible a few system clocks later as a missing or extra strobe. A debug word that fails to persist is visible on the very next debug scan, where the returned value does not equal the word written before.

// File: rtl/jtag_dbg_pkg.sv
package jtag_dbg_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_IDENT  = 4'b0010;
    localparam logic [IR_W-1:0] OP_PASS   = 4'b1111;
    localparam logic [IR_W-1:0] OP_DEBUG  = 4'b1000;
    localparam logic [IR_W-1:0] IR_MARKER = 4'b0101;

    typedef enum logic [3:0] {
        ST_RESET   = 4'd0,
        ST_IDLE    = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        PATH_IDENT = 2'd0,
        PATH_PASS  = 2'd1,
        PATH_DEBUG = 2'd2
    } dr_path_e;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        unique case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return m ? ST_SEL_DR : ST_IDLE;
            default:   return ST_RESET;
        endcase
    endfunction

    function automatic dr_path_e decode_op(input logic [IR_W-1:0] op);
        if (op == OP_IDENT) return PATH_IDENT;
        if (op == OP_DEBUG) return PATH_DEBUG;
        return PATH_PASS;
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_dbg_pkg::*;
(
    input  logic       tck,
    input  logic       tap_rst_n,
    input  logic       tms,
    output tap_state_e state
);
    localparam logic [2:0] HI_LIMIT = 3'd5;

    always_ff @(posedge tck) begin
        if (!tap_rst_n) state <= ST_RESET;
        else            state <= tap_next(state, tms);
    end

    // checker-side count of consecutive high mode-select edges
    logic [2:0] hi_cnt;
    always_ff @(posedge tck) begin
        if (!tap_rst_n || !tms)     hi_cnt <= '0;
        else if (hi_cnt != HI_LIMIT) hi_cnt <= hi_cnt + 3'd1;
    end

    // R7
    tlr_reach_chk: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (hi_cnt == HI_LIMIT) |-> (state == ST_RESET));

endmodule

// File: rtl/jtag_tap_regs.sv
module jtag_tap_regs
    import jtag_dbg_pkg::*;
#(
    parameter int              DR_W     = 32,
    parameter logic [DR_W-1:0] ID_VALUE = 32'h149B51C3
) (
    input  logic            tck,
    input  logic            tap_rst_n,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic            tdo,
    output logic [DR_W-1:0] dbg_word,
    output logic            push_tgl
);
    logic [IR_W-1:0] ir_q;
    logic [IR_W-1:0] ir_sr;
    logic [DR_W-1:0] dr_sr;
    logic            pass_q;
    dr_path_e        path;

    assign path = decode_op(ir_q);

    always_ff @(posedge tck) begin
        if (!tap_rst_n) begin
            ir_q     <= OP_IDENT;
            ir_sr    <= '0;
            dr_sr    <= '0;
            pass_q   <= 1'b0;
            dbg_word <= '0;
            push_tgl <= 1'b0;
        end else begin
            unique case (state)
                ST_RESET: begin
                    ir_q     <= OP_IDENT;
                    dbg_word <= '0;
                end
                ST_CAP_IR: ir_sr <= IR_MARKER;
                ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sr;
                ST_CAP_DR: begin
                    unique case (path)
                        PATH_IDENT: dr_sr  <= ID_VALUE;
                        PATH_DEBUG: dr_sr  <= dbg_word;
                        default:    pass_q <= 1'b0;
                    endcase
                end
                ST_SH_DR: begin
                    if (path == PATH_PASS) pass_q <= tdi;
                    else                   dr_sr  <= {tdi, dr_sr[DR_W-1:1]};
                end
                ST_UPD_DR: begin
                    if (path == PATH_DEBUG) begin
                        dbg_word <= dr_sr;
                        push_tgl <= ~push_tgl;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(negedge tck) begin
        if (!tap_rst_n) tdo <= 1'b0;
        else begin
            unique case (state)
                ST_SH_IR: tdo <= ir_sr[0];
                ST_SH_DR: tdo <= (path == PATH_PASS) ? pass_q : dr_sr[0];
                default:  tdo <= 1'b0;
            endcase
        end
    end

    // R1
    ir_capture_chk: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (state == ST_CAP_IR) |=> (ir_sr == IR_MARKER));

    // R9
    tdo_idle_chk: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (state != ST_SH_IR && state != ST_SH_DR) |-> !tdo);

    // R5
    dbg_update_chk: assert property (@(posedge tck) disable iff (!tap_rst_n)
        (state == ST_UPD_DR && path == PATH_DEBUG) |=> (dbg_word == $past(dr_sr)));

endmodule

// File: rtl/jtag_push_sync.sv
module jtag_push_sync #(
    parameter int DR_W        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tgl,
    input  logic [DR_W-1:0] word_in,
    output logic            push_valid,
    output logic [DR_W-1:0] push_word
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   seen_q;
    logic                   edge_seen;

    assign edge_seen = sync_q[LAST] ^ seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            seen_q     <= 1'b0;
            push_valid <= 1'b0;
            push_word  <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], tgl};
            seen_q     <= sync_q[LAST];
            push_valid <= edge_seen;
            if (edge_seen) push_word <= word_in;
        end
    end

    // R6
    push_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> !push_valid);

endmodule

// File: rtl/jtag_dbg_tap.sv
module jtag_dbg_tap
    import jtag_dbg_pkg::*;
#(
    parameter int              DR_W        = 32,
    parameter logic [DR_W-1:0] ID_VALUE    = 32'h149B51C3,
    parameter int              SYNC_STAGES = 2
) (
    input  logic            tck,
    input  logic            tap_rst_n,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    input  logic            clk,
    input  logic            rst,
    output logic            push_valid,
    output logic [DR_W-1:0] push_word
);
    tap_state_e      state;
    logic [DR_W-1:0] dbg_word;
    logic            push_tgl;

    jtag_tap_fsm u_fsm (
        .tck       (tck),
        .tap_rst_n (tap_rst_n),
        .tms       (tms),
        .state     (state)
    );

    jtag_tap_regs #(.DR_W(DR_W), .ID_VALUE(ID_VALUE)) u_regs (
        .tck       (tck),
        .tap_rst_n (tap_rst_n),
        .tdi       (tdi),
        .state     (state),
        .tdo       (tdo),
        .dbg_word  (dbg_word),
        .push_tgl  (push_tgl)
    );

    jtag_push_sync #(.DR_W(DR_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .tgl        (push_tgl),
        .word_in    (dbg_word),
        .push_valid (push_valid),
        .push_word  (push_word)
    );

endmodule

// File: tb/test_jtag_dbg_tap.sv
module test_jtag_dbg_tap;

    localparam logic [31:0] IDV = 32'h149B51C3;
    localparam logic [3:0]  C_ID = 4'b0010, C_BYP = 4'b1111, C_DBG = 4'b1000;

    logic clk = 1'b0, rst = 1'b1;
    logic tck = 1'b0, tap_rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic mid_tdo, tdo_out;
    logic pv_a, pv_b;
    logic [31:0] pw_a, pw_b;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] qa[$];
    logic [31:0] qb[$];

    always #4 clk = ~clk;

    // device A is nearest the host's data output, device B drives the host input
    jtag_dbg_tap i_jtag_dbg_tap (
        .tck(tck), .tap_rst_n(tap_rst_n), .tms(tms), .tdi(tdi), .tdo(mid_tdo),
        .clk(clk), .rst(rst), .push_valid(pv_a), .push_word(pw_a));

    jtag_dbg_tap i_jtag_dbg_tap_next (
        .tck(tck), .tap_rst_n(tap_rst_n), .tms(tms), .tdi(mid_tdo), .tdo(tdo_out),
        .clk(clk), .rst(rst), .push_valid(pv_b), .push_word(pw_b));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected words as strobes appear
    always @(negedge clk) begin
        if (!rst && pv_a) begin
            if (qa.size() == 0) check(1'b0, "R6 unexpected push dev A", {32'h0, pw_a}, 64'h0);
            else begin
                logic [31:0] e;
                e = qa.pop_front();
                check(pw_a == e, "R6 push word dev A", {32'h0, pw_a}, {32'h0, e});
            end
        end
        if (!rst && pv_b) begin
            if (qb.size() == 0) check(1'b0, "R6 unexpected push dev B", {32'h0, pw_b}, 64'h0);
            else begin
                logic [31:0] e;
                e = qb.pop_front();
                check(pw_b == e, "R6 push word dev B", {32'h0, pw_b}, {32'h0, e});
            end
        end
    end

    task automatic tck_cycle(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #20; o = tdo_out;
        #20; tck = 1'b1;
        #40; tck = 1'b0;
    endtask

    task automatic goto_idle();
        logic o;
        for (int k = 0; k < 5; k++) tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
    endtask

    task automatic scan(input bit is_ir, input int len, input logic [63:0] vin, output logic [63:0] vout);
        logic o;
        vout = '0;
        tck_cycle(1'b1, 1'b0, o);
        if (is_ir) tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            tck_cycle(i == len - 1, vin[i], o);
            vout[i] = o;
        end
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        #1;
        check(tdo_out == 1'b0, "R9 tdo low in idle", {63'h0, tdo_out}, 64'h0);
    endtask

    task automatic pin_reset();
        logic o;
        repeat (10) @(posedge clk);
        rst = 1'b1; tap_rst_n = 1'b0;
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b1, 1'b0, o);
        tap_rst_n = 1'b1;
        repeat (6) @(posedge clk);
        rst = 1'b0;
        tck_cycle(1'b0, 1'b0, o);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] r;
        logic o;
        logic [31:0] da1 = 32'hA5C3_0F17, db1 = 32'h1234_5678;
        logic [31:0] da2 = 32'h8000_0001, db2 = 32'h7FFF_FFFE;
        logic [31:0] da3 = 32'hDEAD_BEEF, da4 = 32'h0BAD_F00D, db4 = 32'hCAFE_0042;
        logic [31:0] da5 = 32'h5555_AAAA, db5 = 32'hFFFF_0000;

        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b1, 1'b0, o);
        tap_rst_n = 1'b1;
        repeat (4) @(posedge clk);
        rst = 1'b0;
        #1;
        check(tdo_out == 1'b0, "R8 tdo after reset", {63'h0, tdo_out}, 64'h0);
        check(pv_a == 1'b0 && pv_b == 1'b0, "R8 no push after reset", {62'h0, pv_a, pv_b}, 64'h0);

        goto_idle();
        // reset default instruction selects the identity word (R7)
        scan(1'b0, 64, 64'h0, r);
        check(r == {IDV, IDV}, "R2 R7 identity after reset", r, {IDV, IDV});

        scan(1'b1, 8, {56'h0, C_ID, C_ID}, r);
        check(r[7:0] == 8'h55, "R1 IR capture marker", r, 64'h55);

        scan(1'b1, 8, {56'h0, C_ID, C_BYP}, r);
        check(r[7:0] == 8'h55, "R1 IR capture marker mixed", r, 64'h55);
        scan(1'b0, 33, {31'h0, 32'h0, 1'b1}, r);
        check(r[32:0] == {IDV, 1'b0}, "R3 R10 identity then pass-through", r, {31'h0, IDV, 1'b0});

        scan(1'b1, 8, {56'h0, C_BYP, C_ID}, r);
        scan(1'b0, 33, 64'h1_0000_0000, r);
        check(r[32:0] == {1'b0, IDV}, "R3 R10 pass-through then identity", r, {31'h0, 1'b0, IDV});

        scan(1'b1, 8, {56'h0, 4'b0111, 4'b0000}, r);
        scan(1'b0, 3, 64'h7, r);
        check(r[2:0] == 3'b100, "R4 unused codes act as pass-through", r, 64'h4);

        scan(1'b1, 8, {56'h0, C_DBG, C_DBG}, r);
        qa.push_back(da1); qb.push_back(db1);
        scan(1'b0, 64, {da1, db1}, r);
        check(r == 64'h0, "R7 debug word cleared after reset", r, 64'h0);

        qa.push_back(da2); qb.push_back(db2);
        scan(1'b0, 64, {da2, db2}, r);
        check(r == {da1, db1}, "R5 debug word returned on next scan", r, {da1, db1});

        scan(1'b1, 8, {56'h0, C_DBG, C_BYP}, r);
        qa.push_back(da3);
        scan(1'b0, 33, {31'h0, da3, 1'b1}, r);
        check(r[32:0] == {da2, 1'b0}, "R5 R10 debug beside pass-through", r, {31'h0, da2, 1'b0});

        scan(1'b1, 8, {56'h0, C_DBG, C_DBG}, r);
        qa.push_back(da4); qb.push_back(db4);
        scan(1'b0, 64, {da4, db4}, r);
        check(r == {da3, db2}, "R5 R6 untouched word kept", r, {da3, db2});

        // abort from inside Shift-IR by five high mode-select edges
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b1, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        tck_cycle(1'b0, 1'b0, o);
        tck_cycle(1'b0, 1'b1, o);
        tck_cycle(1'b0, 1'b1, o);
        goto_idle();
        scan(1'b0, 64, 64'h0, r);
        check(r == {IDV, IDV}, "R7 identity after mode-select reset", r, {IDV, IDV});
        scan(1'b1, 8, {56'h0, C_DBG, C_DBG}, r);
        qa.push_back(32'h0); qb.push_back(32'h0);
        scan(1'b0, 64, 64'h0, r);
        check(r == 64'h0, "R7 debug cleared by mode-select reset", r, 64'h0);

        qa.push_back(da5); qb.push_back(db5);
        scan(1'b0, 64, {da5, db5}, r);
        check(r == 64'h0, "R5 zero word read back", r, 64'h0);

        pin_reset();
        scan(1'b0, 64, 64'h0, r);
        check(r == {IDV, IDV}, "R8 identity after pin reset", r, {IDV, IDV});
        scan(1'b1, 8, {56'h0, C_DBG, C_DBG}, r);
        qa.push_back(32'h0); qb.push_back(32'h0);
        scan(1'b0, 64, 64'h0, r);
        check(r == 64'h0, "R8 debug cleared by pin reset", r, 64'h0);

        repeat (20) @(posedge clk);
        #1;
        check(qa.size() == 0, "R6 all pushes seen dev A", 64'(qa.size()), 64'h0);
        check(qb.size() == 0, "R6 all pushes seen dev B", 64'(qb.size()), 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule